// File: doc/BRIEF.md
# Landing Pad Label Register Unit

This block holds the expected landing-pad label used for forward-edge control-flow checks. The label is 25 bits wide and is kept as three fields: a 9-bit lower field, an 8-bit middle field and an 8-bit upper field. An indirect call or jump site loads the expected label with set operations. The landing pad then verifies that label with check operations that each compare one field against an immediate from the instruction. A mismatch raises an illegal-instruction fault.

The instruction decoder presents one operation per cycle, together with its immediate and a flag that says whether control-flow protection is active at the current privilege level. When protection is inactive, every label operation falls back to a no-effect instruction: the register is left alone, no fault is raised, and the destination register is written with zero. A passing lower-field check drives a landing indication, which the external landing-pad state machine uses to clear its expectation. The middle and upper checks never drive it. A CSR port lets a trap handler save and restore the whole register.

Top module: `lp_label_unit`

## Requirements
- R1: While rst_ni is low and after it is released, csr_rdata_o reads zero until something writes the register.
- R2: With valid_i, cfi_active_i and op_i = 1 (set-lower), the lower field takes imm_i[8:0] at the next clock edge, and the middle and upper fields become zero.
- R3: With valid_i, cfi_active_i and op_i = 2 (set-middle), the middle field takes imm_i[7:0] at the next edge. The other fields keep their values.
- R4: With valid_i, cfi_active_i and op_i = 3 (set-upper), the upper field takes imm_i[7:0] at the next edge. The other fields keep their values.
- R5: With valid_i, cfi_active_i and op_i = 4 (check-lower), fault_o is high in the same cycle when imm_i[8:0] differs from the lower field. On a match, land_o is high instead.
- R6: With valid_i, cfi_active_i and op_i = 5 (check-middle) or 6 (check-upper), fault_o is high in the same cycle when imm_i[7:0] differs from the middle or upper field respectively. land_o stays low for these operations.
- R7: Check operations (op_i 4, 5, 6) never change the register.
- R8: With valid_i high, cfi_active_i low and op_i in 1..6, fault_o and land_o stay low and the register is unchanged. In that cycle, rd_we_o is high and rd_data_o is zero. rd_we_o is low whenever cfi_active_i is high.
- R9: csr_we_i loads all 25 bits from csr_wdata_i at the next edge. It takes priority over any set operation in the same cycle.
- R10: csr_rdata_o presents the register as {upper[24:17], middle[16:9], lower[8:0]}.
- R11: op_i = 0 or 7, or valid_i low, has no effect: no fault, no landing indication, no destination write and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (0 none, 1-3 set lower/middle/upper, 4-6 check lower/middle/upper, 7 none) |
| imm_i | input | 9 | Label immediate from the instruction |
| cfi_active_i | input | 1 | Forward-edge protection active at current privilege |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | 25 | CSR write data |
| csr_rdata_o | output | 25 | Current label register value |
| fault_o | output | 1 | Illegal-instruction fault on label mismatch |
| land_o | output | 1 | Lower-field check passed |
| rd_we_o | output | 1 | Destination write enable (inactive fallback) |
| rd_data_o | output | XLEN | Destination write data, always zero |

## Verification
fault_o, land_o, rd_we_o and rd_data_o are combinational results of the operation currently presented, so they are due in the same cycle. The bench drives each operation just after a falling edge and samples these outputs one nanosecond later, before the next rising edge. Register updates from set operations and CSR writes appear on csr_rdata_o after the following rising edge. The bench compares csr_rdata_o at the next sample point against a behavioural model, which it updates only after that rising edge. Every cycle gets the same comparison, so a register that changes a cycle early or late is caught on the cycle it happens.

// File: rtl/lp_label_pkg.sv
package lp_label_pkg;
  parameter int unsigned LO_W  = 9;
  parameter int unsigned MID_W = 8;
  parameter int unsigned UP_W  = 8;
  localparam int unsigned LBL_W = LO_W + MID_W + UP_W;
  localparam int unsigned IMM_W = LO_W;

  typedef enum logic [2:0] {
    LP_NOP     = 3'd0,
    LP_SET_LO  = 3'd1,
    LP_SET_MID = 3'd2,
    LP_SET_UP  = 3'd3,
    LP_CHK_LO  = 3'd4,
    LP_CHK_MID = 3'd5,
    LP_CHK_UP  = 3'd6,
    LP_RSVD    = 3'd7
  } lp_op_e;

  typedef struct packed {
    logic [UP_W-1:0]  up;
    logic [MID_W-1:0] mid;
    logic [LO_W-1:0]  lo;
  } lp_label_t;

  typedef struct packed {
    logic set_lo;
    logic set_mid;
    logic set_up;
    logic chk_lo;
    logic chk_mid;
    logic chk_up;
  } lp_cmd_t;
endpackage

// File: rtl/lp_label_decode.sv
module lp_label_decode
  import lp_label_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] op_i,
  input  logic       active_i,
  output lp_cmd_t    cmd_o,
  output logic       inert_o
);
  logic is_lp;
  lp_cmd_t raw;

  always_comb begin
    raw = '0;
    unique case (lp_op_e'(op_i))
      LP_SET_LO:  raw.set_lo  = 1'b1;
      LP_SET_MID: raw.set_mid = 1'b1;
      LP_SET_UP:  raw.set_up  = 1'b1;
      LP_CHK_LO:  raw.chk_lo  = 1'b1;
      LP_CHK_MID: raw.chk_mid = 1'b1;
      LP_CHK_UP:  raw.chk_up  = 1'b1;
      default:    raw = '0;
    endcase
  end

  assign is_lp   = |raw;
  assign cmd_o   = (valid_i && active_i) ? raw : '0;
  assign inert_o = valid_i && !active_i && is_lp;
endmodule

// File: rtl/lp_field_cmp.sv
module lp_field_cmp #(
  parameter int unsigned W = 8
) (
  input  logic         en_i,
  input  logic [W-1:0] field_i,
  input  logic [W-1:0] imm_i,
  output logic         miss_o,
  output logic         hit_o
);
  logic eq;
  assign eq     = (field_i == imm_i);
  assign miss_o = en_i && !eq;
  assign hit_o  = en_i && eq;
endmodule

// File: rtl/lp_label_store.sv
module lp_label_store
  import lp_label_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lp_cmd_t          cmd_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             csr_we_i,
  input  logic [LBL_W-1:0] csr_wdata_i,
  output lp_label_t        label_o
);
  lp_label_t q, d;

  always_comb begin
    d = q;
    if (csr_we_i) begin
      d = lp_label_t'(csr_wdata_i);
    end else if (cmd_i.set_lo) begin
      d.lo  = imm_i[LO_W-1:0];
      d.mid = '0;  // new lower label starts a fresh label
      d.up  = '0;
    end else if (cmd_i.set_mid) begin
      d.mid = imm_i[MID_W-1:0];
    end else if (cmd_i.set_up) begin
      d.up = imm_i[UP_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign label_o = q;
endmodule

// File: rtl/lp_label_unit.sv
module lp_label_unit
  import lp_label_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [8:0]       imm_i,
  input  logic             cfi_active_i,
  input  logic             csr_we_i,
  input  logic [24:0]      csr_wdata_i,
  output logic [24:0]      csr_rdata_o,
  output logic             fault_o,
  output logic             land_o,
  output logic             rd_we_o,
  output logic [XLEN-1:0]  rd_data_o
);
  localparam int unsigned NFLD = 3;

  lp_cmd_t   cmd;
  logic      inert;
  lp_label_t label;
  logic [NFLD-1:0] miss, hit;

  lp_label_decode u_dec (
    .valid_i  (valid_i),
    .op_i     (op_i),
    .active_i (cfi_active_i),
    .cmd_o    (cmd),
    .inert_o  (inert)
  );

  lp_label_store u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .imm_i       (imm_i),
    .csr_we_i    (csr_we_i),
    .csr_wdata_i (csr_wdata_i),
    .label_o     (label)
  );

  for (genvar g = 0; g < NFLD; g++) begin : g_cmp
    if (g == 0) begin : g_lo
      lp_field_cmp #(.W(LO_W)) u_cmp (
        .en_i(cmd.chk_lo), .field_i(label.lo), .imm_i(imm_i[LO_W-1:0]),
        .miss_o(miss[g]), .hit_o(hit[g]));
    end else if (g == 1) begin : g_mid
      lp_field_cmp #(.W(MID_W)) u_cmp (
        .en_i(cmd.chk_mid), .field_i(label.mid), .imm_i(imm_i[MID_W-1:0]),
        .miss_o(miss[g]), .hit_o(hit[g]));
    end else begin : g_up
      lp_field_cmp #(.W(UP_W)) u_cmp (
        .en_i(cmd.chk_up), .field_i(label.up), .imm_i(imm_i[UP_W-1:0]),
        .miss_o(miss[g]), .hit_o(hit[g]));
    end
  end

  assign fault_o     = |miss;
  assign land_o      = hit[0];  // only the lower check is a branch target
  assign rd_we_o     = inert;
  assign rd_data_o   = '0;
  assign csr_rdata_o = label;
endmodule

// File: rtl/lp_label_unit_chk.sv
module lp_label_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [2:0]  op_i,
  input logic [8:0]  imm_i,
  input logic        cfi_active_i,
  input logic        csr_we_i,
  input logic [24:0] csr_wdata_i,
  input logic [24:0] csr_rdata_o,
  input logic        fault_o,
  input logic        land_o,
  input logic        rd_we_o
);
  assert_set_lo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfi_active_i && op_i == 3'd1 && !csr_we_i)
    |=> csr_rdata_o == {16'd0, $past(imm_i)});

  assert_set_mid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfi_active_i && op_i == 3'd2 && !csr_we_i)
    |=> csr_rdata_o == {$past(csr_rdata_o[24:17]), $past(imm_i[7:0]), $past(csr_rdata_o[8:0])});

  assert_set_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfi_active_i && op_i == 3'd3 && !csr_we_i)
    |=> csr_rdata_o == {$past(imm_i[7:0]), $past(csr_rdata_o[16:0])});

  assert_land_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    land_o |-> (op_i == 3'd4 && valid_i && cfi_active_i && !fault_o));

  assert_no_land_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5 || op_i == 3'd6) |-> !land_o);

  assert_chk_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {3'd4, 3'd5, 3'd6} && !csr_we_i) |=> $stable(csr_rdata_o));

  assert_inactive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfi_active_i && !csr_we_i) |=> $stable(csr_rdata_o));

  assert_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfi_active_i |-> (!fault_o && !land_o));

  assert_rdwe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (valid_i && !cfi_active_i));

  assert_csr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i |=> csr_rdata_o == $past(csr_wdata_i));

  assert_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || op_i == 3'd0 || op_i == 3'd7) |-> (!fault_o && !land_o && !rd_we_o));

  always_comb begin
    if (!rst_ni) assert_reset_R1: assert (csr_rdata_o == 25'd0);
  end
endmodule

bind lp_label_unit lp_label_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .imm_i(imm_i),
  .cfi_active_i(cfi_active_i), .csr_we_i(csr_we_i), .csr_wdata_i(csr_wdata_i),
  .csr_rdata_o(csr_rdata_o), .fault_o(fault_o), .land_o(land_o), .rd_we_o(rd_we_o)
);

// File: tb/sim_lp_label_unit.sv
`timescale 1ns/1ps
module sim_lp_label_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic [8:0]  imm = '0;
  logic        act = 1'b0;
  logic        we = 1'b0;
  logic [24:0] wd = '0;
  logic [24:0] rdata;
  logic        fault, land, rd_we;
  logic [31:0] rd_data;

  int n_chk = 0, n_bad = 0;
  int m_lo = 0, m_mid = 0, m_up = 0;
  string last_tag = "R1";

  always #2.5 clk = ~clk;

  lp_label_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .imm_i(imm),
    .cfi_active_i(act), .csr_we_i(we), .csr_wdata_i(wd), .csr_rdata_o(rdata),
    .fault_o(fault), .land_o(land), .rd_we_o(rd_we), .rd_data_o(rd_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act_v, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic step(input bit v, input int o, input int im, input bit a,
                      input bit w, input int wdat);
    logic [24:0] exp_r;
    bit ef, el, ew;
    string ftag;
    @(negedge clk);
    valid = v; op = 3'(o); imm = 9'(im); act = a; we = w; wd = 25'(wdat);
    #1;
    exp_r = {8'(m_up), 8'(m_mid), 9'(m_lo)};
    ef = v && a && ((o == 4 && (im & 9'h1ff) != m_lo) ||
                    (o == 5 && (im & 8'hff) != m_mid) ||
                    (o == 6 && (im & 8'hff) != m_up));
    el = v && a && o == 4 && (im & 9'h1ff) == m_lo;
    ew = v && !a && o >= 1 && o <= 6;
    if (!v || o == 0 || o == 7) ftag = "R11";
    else if (!a)                ftag = "R8";
    else if (o == 4)            ftag = "R5";
    else if (o >= 5)            ftag = "R6";
    else                        ftag = "R11";
    check(rdata == exp_r, last_tag, "csr_rdata R10", rdata, exp_r);
    check(fault == ef, ftag, "fault", fault, ef);
    check(land == el, ftag, "land", land, el);
    check(rd_we == ew && rd_data == 0, "R8", "rd_we", rd_we, ew);
    @(posedge clk);
    if (w) begin
      m_lo = wdat & 'h1ff; m_mid = (wdat >> 9) & 'hff; m_up = (wdat >> 17) & 'hff;
      last_tag = "R9";
    end else if (!v || o == 0 || o == 7) last_tag = "R11";
    else if (!a) last_tag = "R8";
    else begin
      case (o)
        1: begin m_lo = im & 'h1ff; m_mid = 0; m_up = 0; last_tag = "R2"; end
        2: begin m_mid = im & 'hff; last_tag = "R3"; end
        3: begin m_up = im & 'hff; last_tag = "R4"; end
        default: last_tag = "R7";
      endcase
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #3;
    check(rdata == 0, "R1", "reset value", rdata, 0);
    we = 1'b1; wd = 25'h1ffffff; valid = 1'b1; op = 3'd1; act = 1'b1; imm = 9'h1ab;
    #6;
    check(rdata == 0, "R1", "held in reset", rdata, 0);
    we = 1'b0; valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    // call-site and landing sequence
    step(1, 1, 'h1de, 1, 0, 0);
    step(1, 2, 'h17, 1, 0, 0);
    step(1, 3, 'h13, 1, 0, 0);
    step(1, 4, 'h1de, 1, 0, 0);
    step(1, 5, 'h17, 1, 0, 0);
    step(1, 6, 'h13, 1, 0, 0);
    // mismatches, incl. ignored bit 8 on 8-bit checks
    step(1, 4, 'h0de, 1, 0, 0);
    step(1, 5, 'h117, 1, 0, 0);
    step(1, 5, 'h18, 1, 0, 0);
    step(1, 6, 'h14, 1, 0, 0);
    // set-lower clears the upper fields
    step(1, 1, 'h005, 1, 0, 0);
    step(1, 5, 'h00, 1, 0, 0);
    step(1, 6, 'h00, 1, 0, 0);
    // inactive: all ops inert
    for (int o = 1; o <= 6; o++) step(1, o, 'h1ff, 0, 0, 0);
    // idle encodings
    step(1, 0, 'h1ff, 1, 0, 0);
    step(1, 7, 'h1ff, 1, 0, 0);
    step(0, 1, 'h1ff, 1, 0, 0);
    step(0, 4, 'h0aa, 1, 0, 0);
    // CSR restore and priority over set
    step(0, 0, 0, 1, 1, 'h1a5c3e7);
    step(1, 1, 'h0ff, 1, 1, 'h0123456);
    step(1, 4, 'h056, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int o, im, r;
      o = int'($urandom_range(0, 7));
      r = int'($urandom_range(0, 3));
      if (r == 0) im = int'($urandom_range(0, 511));
      else if (o == 4) im = m_lo;
      else if (o == 5) im = m_mid | (int'($urandom_range(0, 1)) << 8);
      else if (o == 6) im = m_up;
      else im = int'($urandom_range(0, 511));
      step(1, o, im, $urandom_range(0, 4) != 0, $urandom_range(0, 15) == 0,
           int'($urandom_range(0, 32'h1ffffff)));
    end
    step(0, 0, 0, 1, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule